// File: doc/BRIEF.md
# Hiccup-Mode Fault Restart Timer

This block watches the regulation loop of a switching converter and turns a lost loop into bursts of switching with pauses between them. It counts converter oscillator cycles, marked by a one-clock pulse at each cycle start. A cycle start with the feedback-enable indication high clears the count. If the feedback enable stays absent for a set number of cycles, the block holds the power switch off for an off period. It then lets switching try again.

The first off period after a healthy run is short. If the retry window again passes with no feedback enable, the next off period is long, and long pauses repeat until the loop recovers. A single cycle start with feedback high during a retry window counts as recovery and brings back the healthy state, so a later, unrelated fault again gets the short pause. An immediate-shutdown request skips the timeout and starts the off period in the same clock. All durations are parameters counted in oscillator cycles.

Top module: `hiccup_timer`

## Requirements
- R1: After reset, fault_state is 2'b00 (armed, no earlier fault) and sw_inhibit is 0.
- R2: In the armed state (2'b00) or the retry state (2'b10), a cycle_start pulse with fb_high=1 clears the cycle count. A timeout therefore needs ON_CYCLES cycle starts in a row with fb_high=0.
- R3: In the armed state, the ON_CYCLES-th cycle start in a row with fb_high=0 moves fault_state to 2'b01 (short off) on that clock edge.
- R4: The short off state lasts OFF_FIRST_CYCLES cycle starts. The last of them moves fault_state to 2'b10 (retry).
- R5: In the retry state, ON_CYCLES cycle starts in a row with fb_high=0 move fault_state to 2'b11 (long off).
- R6: The long off state lasts OFF_LONG_CYCLES cycle starts. The last of them moves fault_state back to 2'b10.
- R7: In the retry state, a cycle start with fb_high=1 returns fault_state to 2'b00, so the next timeout gets the short off period again.
- R8: A shut_req high at a clock edge enters the off period on that edge, with or without a cycle start. It enters 2'b01 from the armed state and 2'b11 from the retry state, and it wins over fb_high in the same cycle.
- R9: In either off state, fb_high and shut_req have no effect. The off period runs its full length.
- R10: fb_high with no cycle_start pulse has no effect. Without cycle_start or shut_req, fault_state does not change.
- R11: sw_inhibit is 1 exactly while fault_state is 2'b01 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cycle_start | input | 1 | One-clock pulse at the start of each oscillator cycle |
| fb_high | input | 1 | Feedback enable seen, sampled only together with cycle_start |
| shut_req | input | 1 | Immediate shutdown request |
| sw_inhibit | output | 1 | High while switching must be held off |
| fault_state | output | 2 | 00 armed, 01 short off, 10 retry, 11 long off |

## Verification
The bench probes count boundaries. One run has ON_CYCLES-1 low cycle starts, one high start, and then ON_CYCLES-1 low starts again; a counter that does not clear on feedback would time out early. It checks each off length one cycle start before its end and at its end, so an off-by-one shows up as an early or late exit from the pause. It checks that a recovery in the retry window brings back the short pause; a design that kept the repeat history would give a long one. It checks that shutdown wins over feedback in the same cycle, and that feedback held high between cycle starts leaves a half-full count untouched. Random cycle-start spacing, feedback and shutdown patterns are then compared every clock against a bench reference model.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    ST_ARMED     = 2'b00,
    ST_OFF_FIRST = 2'b01,
    ST_RETRY_ON  = 2'b10,
    ST_OFF_LONG  = 2'b11
  } hic_state_e;

  function automatic logic is_off(input hic_state_e s);
    return (s == ST_OFF_FIRST) || (s == ST_OFF_LONG);
  endfunction

endpackage

// File: rtl/hiccup_rst_sync.sv
module hiccup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/hiccup_limit_sel.sv
module hiccup_limit_sel
  import hiccup_pkg::*;
#(
  parameter int W                = 17,
  parameter int ON_CYCLES        = 3300,
  parameter int OFF_FIRST_CYCLES = 9900,
  parameter int OFF_LONG_CYCLES  = 99000
) (
  input  hic_state_e   state,
  output logic [W-1:0] limit
);

  localparam logic [W-1:0] LIM_ON    = W'(ON_CYCLES);
  localparam logic [W-1:0] LIM_FIRST = W'(OFF_FIRST_CYCLES);
  localparam logic [W-1:0] LIM_LONG  = W'(OFF_LONG_CYCLES);

  always_comb begin
    unique case (state)
      ST_OFF_FIRST: limit = LIM_FIRST;
      ST_OFF_LONG:  limit = LIM_LONG;
      default:      limit = LIM_ON;
    endcase
  end

endmodule

// File: rtl/hiccup_counter.sv
module hiccup_counter #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign done   = tick && (cnt_q == (limit - W'(1)));
  assign cnt_en = clr || tick;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
  import hiccup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fb_high,
  input  logic       shut_req,
  input  logic       done,
  output hic_state_e state,
  output logic       clr
);

  hic_state_e state_q;
  hic_state_e state_d;
  logic       fb_seen;

  assign fb_seen = tick && fb_high;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED: begin
        if (shut_req)     state_d = ST_OFF_FIRST;
        else if (fb_seen) state_d = ST_ARMED;
        else if (done)    state_d = ST_OFF_FIRST;
      end
      ST_RETRY_ON: begin
        if (shut_req)     state_d = ST_OFF_LONG;
        else if (fb_seen) state_d = ST_ARMED;
        else if (done)    state_d = ST_OFF_LONG;
      end
      ST_OFF_FIRST: begin
        if (done) state_d = ST_RETRY_ON;
      end
      ST_OFF_LONG: begin
        if (done) state_d = ST_RETRY_ON;
      end
      default: state_d = ST_ARMED;
    endcase
  end

  assign clr = (state_d != state_q) || (fb_seen && !is_off(state_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARMED;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/hiccup_timer.sv
module hiccup_timer
  import hiccup_pkg::*;
#(
  parameter int ON_CYCLES        = 3300,
  parameter int OFF_FIRST_CYCLES = 9900,
  parameter int OFF_LONG_CYCLES  = 99000,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_start,
  input  logic       fb_high,
  input  logic       shut_req,
  output logic       sw_inhibit,
  output logic [1:0] fault_state
);

  localparam int MAX_A = (ON_CYCLES > OFF_FIRST_CYCLES) ? ON_CYCLES : OFF_FIRST_CYCLES;
  localparam int MAX_CYC = (MAX_A > OFF_LONG_CYCLES) ? MAX_A : OFF_LONG_CYCLES;
  localparam int CW = $clog2(MAX_CYC + 1);

  logic         rst_sync_n;
  logic [CW-1:0] limit;
  logic         done;
  logic         clr;
  hic_state_e   state;

  hiccup_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hiccup_limit_sel #(
    .W                (CW),
    .ON_CYCLES        (ON_CYCLES),
    .OFF_FIRST_CYCLES (OFF_FIRST_CYCLES),
    .OFF_LONG_CYCLES  (OFF_LONG_CYCLES)
  ) u_lim (
    .state (state),
    .limit (limit)
  );

  hiccup_counter #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (cycle_start),
    .clr   (clr),
    .limit (limit),
    .done  (done)
  );

  hiccup_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (cycle_start),
    .fb_high  (fb_high),
    .shut_req (shut_req),
    .done     (done),
    .state    (state),
    .clr      (clr)
  );

  assign sw_inhibit  = is_off(state);
  assign fault_state = state;

endmodule

// File: rtl/hiccup_timer_chk.sv
module hiccup_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cycle_start,
  input logic       fb_high,
  input logic       shut_req,
  input logic       sw_inhibit,
  input logic [1:0] fault_state
);

  assert_inhibit_map_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_inhibit == ((fault_state == 2'b01) || (fault_state == 2'b11)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_start && !shut_req) |=> $stable(fault_state));

  assert_shut_from_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_req && fault_state == 2'b00) |=> (fault_state == 2'b01));

  assert_shut_from_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_req && fault_state == 2'b10) |=> (fault_state == 2'b11));

  assert_armed_exits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state == 2'b00) |=> (fault_state == 2'b00 || fault_state == 2'b01));

  assert_retry_exits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state == 2'b10) |=> (fault_state != 2'b01));

  assert_short_off_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state == 2'b01) |=> (fault_state == 2'b01 || fault_state == 2'b10));

  assert_long_off_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state == 2'b11) |=> (fault_state == 2'b11 || fault_state == 2'b10));

  assert_fb_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && fb_high && !shut_req && fault_state == 2'b00) |=> (fault_state == 2'b00));

  assert_fb_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && fb_high && !shut_req && fault_state == 2'b10) |=> (fault_state == 2'b00));

endmodule

bind hiccup_timer hiccup_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cycle_start (cycle_start),
  .fb_high     (fb_high),
  .shut_req    (shut_req),
  .sw_inhibit  (sw_inhibit),
  .fault_state (fault_state)
);

// File: tb/sim_hiccup_timer.sv
module sim_hiccup_timer;

  localparam int CLK_PERIOD = 10;
  localparam int ON_N   = 6;
  localparam int OFF1_N = 10;
  localparam int OFF2_N = 25;

  logic       clk;
  logic       rst_n;
  logic       cycle_start;
  logic       fb_high;
  logic       shut_req;
  logic       sw_inhibit;
  logic [1:0] fault_state;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state
  logic [1:0] m_st;
  int         m_cnt;
  bit         model_on = 0;

  hiccup_timer #(
    .ON_CYCLES        (ON_N),
    .OFF_FIRST_CYCLES (OFF1_N),
    .OFF_LONG_CYCLES  (OFF2_N)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .fb_high     (fb_high),
    .shut_req    (shut_req),
    .sw_inhibit  (sw_inhibit),
    .fault_state (fault_state)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_inh(input logic [1:0] st);
    return (st == 2'b01) || (st == 2'b11);
  endfunction

  function automatic int lim_of(input logic [1:0] st);
    if (st == 2'b01) return OFF1_N;
    if (st == 2'b11) return OFF2_N;
    return ON_N;
  endfunction

  // model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st  <= 2'b00;
      m_cnt <= 0;
    end else if (m_st == 2'b00 || m_st == 2'b10) begin
      if (shut_req) begin
        m_st <= (m_st == 2'b00) ? 2'b01 : 2'b11; m_cnt <= 0;
      end else if (cycle_start && fb_high) begin
        m_st <= 2'b00; m_cnt <= 0;
      end else if (cycle_start) begin
        if (m_cnt + 1 == lim_of(m_st)) begin
          m_st <= (m_st == 2'b00) ? 2'b01 : 2'b11; m_cnt <= 0;
        end else m_cnt <= m_cnt + 1;
      end
    end else if (cycle_start) begin
      if (m_cnt + 1 == lim_of(m_st)) begin
        m_st <= 2'b10; m_cnt <= 0;
      end else m_cnt <= m_cnt + 1;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [1:0] exp_st);
    total++;
    if (fault_state !== exp_st || sw_inhibit !== exp_inh(exp_st)) begin
      bad++;
      $display("FAIL %s: state=%b inhibit=%b expected state=%b inhibit=%b",
               tag, fault_state, sw_inhibit, exp_st, exp_inh(exp_st));
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) chk("R11 model", m_st);
  end

  task automatic tick(input logic fb, input logic sd, input int gap);
    @(negedge clk);
    cycle_start = 1'b1; fb_high = fb; shut_req = sd;
    @(negedge clk);
    cycle_start = 1'b0; shut_req = 1'b0; fb_high = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic ticks(input int n, input logic fb, input logic sd);
    for (int i = 0; i < n; i++) tick(fb, sd, 1);
  endtask

  task automatic shut_pulse();
    @(negedge clk);
    shut_req = 1'b1;
    @(negedge clk);
    shut_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; cycle_start = 1'b0; fb_high = 1'b0; shut_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset", 2'b00);
    model_on = 1;

    // R2: feedback clears the count
    ticks(ON_N - 1, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1);
    ticks(ON_N - 1, 1'b0, 1'b0);
    chk("R2 count cleared", 2'b00);
    tick(1'b0, 1'b0, 1);
    chk("R3 timeout short off", 2'b01);

    // R9: inputs ignored in off; R4 length
    ticks(OFF1_N - 1, 1'b1, 1'b1);
    chk("R9 off ignores inputs", 2'b01);
    tick(1'b0, 1'b0, 2);
    chk("R4 short off end", 2'b10);

    // R5 retry timeout
    ticks(ON_N - 1, 1'b0, 1'b0);
    chk("R5 before timeout", 2'b10);
    tick(1'b0, 1'b0, 1);
    chk("R5 long off", 2'b11);

    // R6 long length
    ticks(OFF2_N - 1, 1'b0, 1'b0);
    chk("R6 before end", 2'b11);
    tick(1'b0, 1'b0, 1);
    chk("R6 long off end", 2'b10);

    // R7 recovery restores short pause
    tick(1'b1, 1'b0, 1);
    chk("R7 recovery", 2'b00);
    ticks(ON_N, 1'b0, 1'b0);
    chk("R7 fresh fault", 2'b01);
    ticks(OFF1_N - 1, 1'b0, 1'b0);
    chk("R7 short again", 2'b01);
    tick(1'b0, 1'b0, 1);
    chk("R7 short end", 2'b10);

    // R8 shutdown
    shut_pulse();
    chk("R8 shut from retry", 2'b11);
    ticks(OFF2_N, 1'b0, 1'b0);
    chk("R6 after shut", 2'b10);
    tick(1'b1, 1'b0, 1);
    chk("R7 back to armed", 2'b00);
    shut_pulse();
    chk("R8 shut from armed", 2'b01);
    ticks(OFF1_N, 1'b0, 1'b0);
    chk("R4 after shut", 2'b10);
    tick(1'b1, 1'b1, 1);
    chk("R8 shut beats fb", 2'b11);
    ticks(OFF2_N, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1);
    chk("R7 armed again", 2'b00);

    // R10 feedback without cycle start
    ticks(ON_N - 1, 1'b0, 1'b0);
    @(negedge clk);
    fb_high = 1'b1;
    repeat (5) @(negedge clk);
    fb_high = 1'b0;
    chk("R10 no tick no change", 2'b00);
    tick(1'b0, 1'b0, 1);
    chk("R10 fb without tick ignored", 2'b01);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) shut_pulse();
      else tick(($urandom_range(0, 3) == 0), ($urandom_range(0, 49) == 0),
                $urandom_range(0, 3));
    end
    chk("R11 random end", m_st);
    finish_run();
  end

endmodule